// File: doc/BRIEF.md
# Load Driver Protection Supervisor

This block sits between a latched 16-bit control word and six power switches: three low-side and three high-side. It takes the control word and decides which switches may actually conduct. It applies the standby, supply-fault, short-circuit and thermal rules. It also builds the 16-bit diagnostic word that the serial front end shifts back to the host. The analog comparators supply the fault flags, and the serial shifter supplies the control word together with a one-cycle commit strobe.

The block has two delay paths, each counted on a half-millisecond tick. The supply path covers over- and undervoltage. The short-circuit path has one timer per channel. A single control bit chooses between a long and a short delay for both paths. Supply faults and shorts leave sticky flags that only a committed reset request clears. A thermal shutdown latches the block into a state in which every output is off and the diagnostic word reads all ones.

Top module: `lds_supervisor`

## Requirements
- R1: After reset the stored control word has bit 15 (run) set, bit 14 (long delay) set, bit 13 (open-load test, active low) set and channel bits clear, so en_o reads 0 and status_o reads 0 while no faults are present.
- R2: Control bits 1..6 command channels 0..5 (LS1, HS1, LS2, HS2, LS3, HS3). With no fault and no standby, en_o[k] equals control bit k+1 of the last committed word.
- R3: While control bit 13 is high, status bits 1..6 show en_o[0..5], bits 7..12 read 0, and bit 0 follows tw_i.
- R4: While control bit 13 is low, status bit k+1 reads ol_i[k] AND NOT control bit k+1, so an open load is reported only on channels that are commanded off. en_o still follows R2.
- R5: Standby applies when control bit 15 is low or inh_ni is low. In standby en_o is 0 and status bit 14 reads 1. Otherwise bit 14 reads 0.
- R6: When ov_i or uv_i stays high for 28 ticks with bit 14 high, or for 7 ticks with bit 14 low, every output turns off. Fewer ticks leave the outputs on. One cycle after the shutdown, status bit 15 is set.
- R7: When the supply fault goes away, the outputs return at once. Status bit 15 stays set until a commit that carries bit 0 high.
- R8: If the supply fault clears before the delay ends, the supply timer restarts from zero.
- R9: A channel that is on and sees sc_i[k] for 200 ticks (bit 14 high) or 25 ticks (bit 14 low) is latched off. Other channels are not affected, and status bit 13 is set.
- R10: A latched channel is released by a commit with bit 0 high, or by a commit that writes its own channel bit low. Status bit 13 clears only on a commit with bit 0 high.
- R11: A high tsd_i latches a shutdown. en_o then reads 0 and status_o reads 16'hFFFF until a commit with bit 0 high arrives while tsd_i is low.
- R12: ctrl_i and its bit 0 have no effect unless commit_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every half millisecond |
| commit_i | input | 1 | Strobe that stores ctrl_i |
| ctrl_i | input | 16 | Control word from the serial front end |
| inh_ni | input | 1 | Hardware inhibit pin, low = standby |
| ov_i | input | 1 | Supply overvoltage flag |
| uv_i | input | 1 | Supply undervoltage flag |
| sc_i | input | 6 | Per-channel short-circuit flags |
| ol_i | input | 6 | Per-channel open-load flags |
| tw_i | input | 1 | Temperature warning |
| tsd_i | input | 1 | Thermal shutdown flag |
| en_o | output | 6 | Gated switch enables |
| status_o | output | 16 | Diagnostic word |

## Verification
The bench applies tick counts one below each delay threshold and exactly at it, for both delay settings. A timer that is off by one would either shut down early or not shut down at all. It interrupts a supply fault partway through and then reapplies it, to expose a timer that does not restart. It checks that a short latches only its own channel and that rewriting the channel bit releases it while status bit 13 stays set. It sweeps every channel pattern against every open-load pattern, which catches a swapped bit order or an open load reported on a channel that is switched on. The thermal state is checked to survive a commit without the reset request, since a design that cleared it on any commit would return to normal status too early.

// File: rtl/lds_pkg.sv
package lds_pkg;
  localparam int NCH = 6;

  typedef struct packed {
    logic           si;     // 15: run (low = standby)
    logic           sct;    // 14: long delays
    logic           old_n;  // 13: open-load test, active low
    logic [5:0]     rsv;    // 12..7
    logic [NCH-1:0] ch;     // 6..1
    logic           srr;    // 0: clear sticky flags
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{si: 1'b1, sct: 1'b1, old_n: 1'b1,
                                 rsv: 6'd0, ch: '0, srr: 1'b0};
endpackage

// File: rtl/lds_ctrl_reg.sv
module lds_ctrl_reg
  import lds_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  input  logic [15:0]    ctrl_i,
  output ctrl_t          ctrl_o,
  output logic           srr_o,
  output logic [NCH-1:0] ch_clr_o
);
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  assign ctrl_d   = ctrl_t'(ctrl_i);
  assign srr_o    = commit_i & ctrl_d.srr;
  assign ch_clr_o = {NCH{commit_i}} & ~ctrl_d.ch;
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= CTRL_RST;
    else if (commit_i) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/lds_delay_timer.sv
module lds_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/lds_status_mux.sv
module lds_status_mux
  import lds_pkg::*;
(
  input  ctrl_t          ctrl_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] ol_i,
  input  logic           tw_i,
  input  logic           scd_i,
  input  logic           standby_i,
  input  logic           psf_i,
  input  logic           tsd_i,
  output logic [15:0]    status_o
);
  logic [NCH-1:0] ch_stat;

  // open-load test reports only on channels commanded off
  assign ch_stat = ctrl_i.old_n ? en_i : (ol_i & ~ctrl_i.ch);

  always_comb begin
    if (tsd_i) status_o = '1;
    else       status_o = {psf_i, standby_i, scd_i, 6'd0, ch_stat, tw_i};
  end
endmodule

// File: rtl/lds_supervisor.sv
module lds_supervisor
  import lds_pkg::*;
#(
  parameter int SUP_LONG  = 28,
  parameter int SUP_SHORT = 7,
  parameter int SC_LONG   = 200,
  parameter int SC_SHORT  = 25
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           commit_i,
  input  logic [15:0]    ctrl_i,
  input  logic           inh_ni,
  input  logic           ov_i,
  input  logic           uv_i,
  input  logic [NCH-1:0] sc_i,
  input  logic [NCH-1:0] ol_i,
  input  logic           tw_i,
  input  logic           tsd_i,
  output logic [NCH-1:0] en_o,
  output logic [15:0]    status_o
);
  localparam int LIM_A   = (SUP_LONG > SUP_SHORT) ? SUP_LONG : SUP_SHORT;
  localparam int LIM_B   = (SC_LONG > SC_SHORT) ? SC_LONG : SC_SHORT;
  localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  ctrl_t            ctrl_q;
  logic             srr;
  logic [NCH-1:0]   ch_clr;
  logic [CNT_W-1:0] sup_lim, sc_lim;
  logic             sup_off, standby;
  logic             psf_q, scd_q, tsd_q;
  logic [NCH-1:0]   sc_exp, sc_lat_q;

  lds_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_i),
    .ctrl_i   (ctrl_i),
    .ctrl_o   (ctrl_q),
    .srr_o    (srr),
    .ch_clr_o (ch_clr)
  );

  assign sup_lim = ctrl_q.sct ? CNT_W'(SUP_LONG) : CNT_W'(SUP_SHORT);
  assign sc_lim  = ctrl_q.sct ? CNT_W'(SC_LONG)  : CNT_W'(SC_SHORT);
  assign standby = ~ctrl_q.si | ~inh_ni;

  lds_delay_timer #(.CNT_W(CNT_W)) u_sup_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (ov_i | uv_i),
    .limit_i   (sup_lim),
    .expired_o (sup_off)
  );

  assign en_o = ctrl_q.ch & ~sc_lat_q &
                {NCH{~standby & ~sup_off & ~tsd_q}};

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    lds_delay_timer #(.CNT_W(CNT_W)) u_sc_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .run_i     (sc_i[k] & en_o[k]),
      .limit_i   (sc_lim),
      .expired_o (sc_exp[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    sc_lat_q[k] <= 1'b0;
      else if (sc_exp[k])             sc_lat_q[k] <= 1'b1;
      else if (srr || ch_clr[k])      sc_lat_q[k] <= 1'b0;
    end
  end

  // sticky flags: set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psf_q <= 1'b0;
      scd_q <= 1'b0;
      tsd_q <= 1'b0;
    end else begin
      psf_q <= sup_off | (psf_q & ~srr);
      scd_q <= (|sc_exp) | (scd_q & ~srr);
      tsd_q <= tsd_i | (tsd_q & ~srr);
    end
  end

  lds_status_mux u_stat (
    .ctrl_i    (ctrl_q),
    .en_i      (en_o),
    .ol_i      (ol_i),
    .tw_i      (tw_i),
    .scd_i     (scd_q),
    .standby_i (standby),
    .psf_i     (psf_q),
    .tsd_i     (tsd_q),
    .status_o  (status_o)
  );
endmodule

// File: rtl/lds_supervisor_chk.sv
module lds_supervisor_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        commit_i,
  input logic        tsd_i,
  input logic [5:0]  en_o,
  input logic [15:0] status_o,
  input logic [15:0] ctrl_q_i,
  input logic        sup_off_i
);
  AST_STANDBY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[14] && status_o != 16'hFFFF) |-> en_o == 6'd0);  // R5
  AST_SUP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_off_i |=> status_o[15]);  // R6
  AST_PSF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[15] && !commit_i) |=> status_o[15]);  // R7
  AST_SCD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[13] && !commit_i) |=> status_o[13]);  // R10
  AST_TSD_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_i |=> (status_o == 16'hFFFF && en_o == 6'd0));  // R11
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ctrl_q_i));  // R12
endmodule

bind lds_supervisor lds_supervisor_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .commit_i  (commit_i),
  .tsd_i     (tsd_i),
  .en_o      (en_o),
  .status_o  (status_o),
  .ctrl_q_i  (ctrl_q),
  .sup_off_i (sup_off)
);

// File: tb/lds_supervisor_tb_top.sv
module lds_supervisor_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        commit_i = 1'b0;
  logic [15:0] ctrl_i = '0;
  logic        inh_ni = 1'b1;
  logic        ov_i = 1'b0, uv_i = 1'b0, tw_i = 1'b0, tsd_i = 1'b0;
  logic [5:0]  sc_i = '0, ol_i = '0;
  logic [5:0]  en_o;
  logic [15:0] status_o;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  lds_supervisor dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .commit_i(commit_i),
    .ctrl_i(ctrl_i), .inh_ni(inh_ni), .ov_i(ov_i), .uv_i(uv_i),
    .sc_i(sc_i), .ol_i(ol_i), .tw_i(tw_i), .tsd_i(tsd_i),
    .en_o(en_o), .status_o(status_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic commit(input logic [15:0] w);
    ctrl_i = w;
    commit_i = 1'b1;
    @(negedge clk_i);
    commit_i = 1'b0;
  endtask

  // control word: {si, sct, old_n, 6'b0, ch, srr}
  function automatic logic [15:0] cw(input logic si, input logic sct, input logic oldn,
                                     input logic [5:0] ch, input logic srr);
    return {si, sct, oldn, 6'd0, ch, srr};
  endfunction

  initial begin
    #5ms;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    check("R1 en", en_o, 0);
    check("R1 status", status_o, 0);

    // R12: writes without commit are ignored
    ctrl_i = cw(1, 1, 1, 6'h3F, 1);
    idle(2);
    check("R12 no commit en", en_o, 0);

    // R2/R3 sweep
    for (int p = 0; p < 64; p++) begin
      commit(cw(1, 1, 1, 6'(p), 0));
      check("R2 en", en_o, p);
      check("R3 status", status_o, p << 1);
    end
    tw_i = 1'b1;
    #1 check("R3 tw bit", status_o, 16'h007F);
    tw_i = 1'b0;

    // R4 open-load sweep
    for (int p = 0; p < 64; p++) begin
      commit(cw(1, 1, 0, 6'(p), 0));
      for (int o = 0; o < 64; o++) begin
        ol_i = 6'(o);
        #1;
        check("R4 status", status_o, 32'((o & ~p & 63) << 1));
        check("R4 en", en_o, p);
        @(negedge clk_i);
      end
    end
    ol_i = '0;

    // R5 standby
    commit(cw(1, 1, 1, 6'h3F, 0));
    inh_ni = 1'b0;
    #1 check("R5 pin en", en_o, 0);
    check("R5 pin bit14", status_o[14], 1);
    inh_ni = 1'b1;
    #1 check("R5 run en", en_o, 6'h3F);
    check("R5 run bit14", status_o[14], 0);
    idle(1);
    commit(cw(0, 1, 1, 6'h3F, 0));
    check("R5 si en", en_o, 0);
    check("R5 si bit14", status_o[14], 1);

    // R6/R7 long supply delay
    commit(cw(1, 1, 1, 6'h3F, 0));
    uv_i = 1'b1;
    ticks(27); idle(2);
    check("R6 long early en", en_o, 6'h3F);
    check("R6 long early psf", status_o[15], 0);
    ticks(1); idle(2);
    check("R6 long off", en_o, 0);
    check("R6 psf set", status_o[15], 1);
    uv_i = 1'b0;
    idle(1);
    check("R7 recover en", en_o, 6'h3F);
    check("R7 psf held", status_o[15], 1);
    commit(cw(1, 1, 1, 6'h3F, 0));
    check("R7 psf held no srr", status_o[15], 1);
    commit(cw(1, 1, 1, 6'h3F, 1));
    check("R7 psf cleared", status_o[15], 0);

    // R6 short delay, R8 restart
    commit(cw(1, 0, 1, 6'h3F, 0));
    ov_i = 1'b1;
    ticks(6); idle(2);
    check("R6 short early", en_o, 6'h3F);
    ticks(1); idle(2);
    check("R6 short off", en_o, 0);
    ov_i = 1'b0;
    commit(cw(1, 0, 1, 6'h3F, 1));
    ov_i = 1'b1; ticks(5);
    ov_i = 1'b0; idle(2);
    ov_i = 1'b1; ticks(5); idle(2);
    check("R8 restart en", en_o, 6'h3F);
    check("R8 restart psf", status_o[15], 0);
    ov_i = 1'b0;
    idle(1);

    // R9/R10 short circuit, short delay
    sc_i = 6'b000100;
    ticks(24); idle(2);
    check("R9 short early", en_o, 6'h3F);
    check("R9 scd early", status_o[13], 0);
    ticks(1); idle(2);
    check("R9 latched", en_o, 6'h3B);
    check("R9 scd", status_o[13], 1);
    sc_i = '0;
    idle(2);
    check("R10 stays latched", en_o, 6'h3B);
    commit(cw(1, 0, 1, 6'h3F, 0));
    check("R10 rewrite high keeps", en_o, 6'h3B);
    commit(cw(1, 0, 1, 6'h3B, 0));
    check("R10 written low", en_o, 6'h3B);
    commit(cw(1, 0, 1, 6'h3F, 0));
    check("R10 released", en_o, 6'h3F);
    check("R10 scd held", status_o[13], 1);
    commit(cw(1, 0, 1, 6'h3F, 1));
    check("R10 scd cleared", status_o[13], 0);

    // R9 long delay, R10 release by SRR
    commit(cw(1, 1, 1, 6'h3F, 0));
    sc_i = 6'b100000;
    ticks(199); idle(2);
    check("R9 long early", en_o, 6'h3F);
    ticks(1); idle(2);
    check("R9 long latched", en_o, 6'h1F);
    sc_i = '0;
    commit(cw(1, 1, 1, 6'h3F, 1));
    check("R10 srr release", en_o, 6'h3F);
    check("R10 srr scd", status_o[13], 0);

    // R11 thermal shutdown
    tsd_i = 1'b1; idle(1);
    tsd_i = 1'b0; idle(2);
    check("R11 all ones", status_o, 16'hFFFF);
    check("R11 en off", en_o, 0);
    commit(cw(1, 1, 1, 6'h3F, 0));
    check("R11 held", status_o, 16'hFFFF);
    commit(cw(1, 1, 1, 6'h3F, 1));
    check("R11 cleared", status_o, 16'h007E);
    check("R11 en back", en_o, 6'h3F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule